// File: doc/BRIEF.md
# Byte-Serial Register Write Deserializer

This block sits at the receiving end of a narrow configuration path. A command comes in as a stream of bytes on an 8-bit bus, one byte per clock, and the block turns it into a single parallel register write. The first byte is marked by a strobe. The first two bytes form a 16-bit address. The bytes after them form the data word.

The full address is compared with a base value under a mask, and only commands that fall inside this window are kept. For such a command the block presents the low bits of the address as a local register index, together with the assembled data word and a write enable that lasts one cycle. Commands outside the window are still read to their end, but produce nothing. The block does not decide which register the index refers to, and it sends no reply.

Top module: `bserial_wr_deser`

## Requirements
- R1: Bytes arrive on consecutive clocks starting with the strobed byte. Byte 0 is address bits 7:0 and byte 1 is address bits 15:8. Data byte k (byte k+2 of the command) fills data bits 8k+7:8k, so the data is little-endian.
- R2: A command is accepted when `(address & ADDR_MASK) == (BASE_ADDR & ADDR_MASK)`. Address bits outside the mask do not affect acceptance.
- R3: For an accepted command, `reg_we_o` is high for exactly one cycle. That cycle is the one right after the clock edge that samples the last byte of the command.
- R4: `reg_addr_o` carries address bits LOC_AW-1:0 of the accepted command, and `reg_data_o` carries its data word, during the write-enable cycle.
- R5: A command outside the window is consumed in full and raises no write enable.
- R6: A strobe that arrives while a command is in progress restarts collection with that byte as address byte 0. The partial command is dropped. This also holds when the strobe falls in the slot of the last byte.
- R7: Bytes presented while no command is in progress and the strobe is low are ignored.
- R8: Reset clears the byte counter, the write enable and both output words. Bytes left over from a command that was cut off by reset never cause a write.
- R9: `reg_addr_o` and `reg_data_o` change only together with a write enable. Otherwise they hold the values of the last accepted command.
- R10: A strobe in the clock right after the last byte of a command starts the next command, and both commands are handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| ser_byte_i | input | 8 | Command byte stream |
| ser_stb_i | input | 1 | High together with the first byte of a command |
| reg_addr_o | output | LOC_AW | Local register index of the accepted write |
| reg_data_o | output | DATA_W | Assembled write data |
| reg_we_o | output | 1 | One-cycle write enable |

## Verification
The bench targets four kinds of error, each with a visible symptom:
- Swapped byte order shows up as scrambled data or index words.
- A mask applied to only one side of the comparison accepts addresses it should reject, or rejects ones it should accept. The bench probes this with addresses whose bits outside the mask are set.
- A strobe ignored in the middle of a command, or in the last-byte slot, would issue a spurious write that mixes two commands.
- A counter that survives reset would turn the leftover bytes of a cut-off command into a write.

Back-to-back commands check that the idle turnaround cycle is not required. Idle bytes without a strobe check that nothing is captured between commands.

// File: rtl/bsd_pkg.sv
`timescale 1ns/1ps
package bsd_pkg;
  // window test: only bits under the mask take part
  function automatic logic addr_in_window(input logic [15:0] a,
                                          input logic [15:0] base,
                                          input logic [15:0] mask);
    return ((a ^ base) & mask) == 16'h0000;
  endfunction

  // little-endian join of two address bytes
  function automatic logic [15:0] join_addr(input logic [7:0] lo,
                                            input logic [7:0] hi);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/bsd_seq.sv
`timescale 1ns/1ps
// Byte position tracker: 0 = idle, k = k bytes of the command already taken
module bsd_seq #(
  parameter int NUM_BYTES = 6,
  localparam int CW = $clog2(NUM_BYTES),
  localparam int SLOTS = NUM_BYTES - 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             stb_i,
  output logic [CW-1:0]    cnt_o,
  output logic [SLOTS-1:0] store_en_o,
  output logic             last_byte_o
);
  localparam logic [CW-1:0] LAST_POS = CW'(NUM_BYTES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)                cnt <= '0;
    else if (stb_i)           cnt <= CW'(1);
    else if (cnt == LAST_POS) cnt <= '0;
    else if (cnt != '0)       cnt <= cnt + CW'(1);
  end

  assign last_byte_o = !stb_i && (cnt == LAST_POS);
  assign cnt_o       = cnt;

  for (genvar i = 0; i < SLOTS; i++) begin : g_en
    if (i == 0) begin : g_first
      assign store_en_o[i] = stb_i;
    end else begin : g_rest
      assign store_en_o[i] = !stb_i && (cnt == CW'(i));
    end
  end
endmodule

// File: rtl/bsd_collect.sv
`timescale 1ns/1ps
// Byte store: holds every byte but the last; the last one is taken live
module bsd_collect #(
  parameter int NUM_BYTES = 6,
  localparam int SLOTS = NUM_BYTES - 1,
  localparam int DBYTES = NUM_BYTES - 2,
  localparam int DATA_W = 8 * DBYTES
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [SLOTS-1:0]  store_en_i,
  input  logic [7:0]        byte_i,
  output logic [15:0]       full_addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0] slot [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)              slot[i] <= '0;
      else if (store_en_i[i]) slot[i] <= byte_i;
    end
  end

  assign full_addr_o = bsd_pkg::join_addr(slot[0], slot[1]);

  for (genvar j = 0; j < DBYTES - 1; j++) begin : g_data
    assign data_o[8*j +: 8] = slot[j+2];
  end
  assign data_o[DATA_W-1 -: 8] = byte_i;
endmodule

// File: rtl/bsd_chk.sv
`timescale 1ns/1ps
module bsd_chk #(
  parameter int NUM_BYTES = 6,
  parameter int LOC_AW = 4,
  localparam int CW = $clog2(NUM_BYTES),
  localparam int DATA_W = 8 * (NUM_BYTES - 2)
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              stb_i,
  input logic [CW-1:0]     cnt_w,
  input logic              last_w,
  input logic              hit_w,
  input logic              we_o,
  input logic [LOC_AW-1:0] addr_o,
  input logic [DATA_W-1:0] data_o
);
  // R2: last byte of a window command must fire
  a_r2_hit_writes: assert property (@(posedge clk_i) disable iff (rst_i)
    (last_w && hit_w) |=> we_o);
  // R5: outside the window, nothing fires
  a_r5_miss_silent: assert property (@(posedge clk_i) disable iff (rst_i)
    (last_w && !hit_w) |=> !we_o);
  // R3: enable is a single-cycle pulse tied to a completed command
  a_r3_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
    we_o |=> !we_o);
  a_r3_after_last: assert property (@(posedge clk_i) disable iff (rst_i)
    we_o |-> $past(last_w));
  // R6: strobe always restarts at position one
  a_r6_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    stb_i |=> (cnt_w == CW'(1)));
  // R9: outputs hold without a write
  a_r9_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !we_o |-> ($stable(data_o) && $stable(addr_o)));
  // R8: reset state
  a_r8_reset: assert property (@(posedge clk_i)
    rst_i |-> (!we_o && cnt_w == '0));
endmodule

bind bserial_wr_deser bsd_chk #(.NUM_BYTES(NUM_BYTES), .LOC_AW(LOC_AW)) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .stb_i  (ser_stb_i),
  .cnt_w  (byte_cnt),
  .last_w (last_byte),
  .hit_w  (addr_hit),
  .we_o   (reg_we_o),
  .addr_o (reg_addr_o),
  .data_o (reg_data_o)
);

// File: rtl/bserial_wr_deser.sv
`timescale 1ns/1ps
module bserial_wr_deser #(
  parameter logic [15:0] BASE_ADDR = 16'h0120,
  parameter logic [15:0] ADDR_MASK = 16'h03F0,
  parameter int NUM_BYTES = 6,
  parameter int LOC_AW = 4,
  localparam int DATA_W = 8 * (NUM_BYTES - 2),
  localparam int CW = $clog2(NUM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [7:0]        ser_byte_i,
  input  logic              ser_stb_i,
  output logic [LOC_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              reg_we_o
);
  localparam int SLOTS = NUM_BYTES - 1;

  // named internal events, also used by the bound checker
  logic [CW-1:0]     byte_cnt;
  logic [SLOTS-1:0]  store_en;
  logic              last_byte;
  logic [15:0]       full_addr;
  logic [DATA_W-1:0] data_word;
  logic              addr_hit;
  logic              commit;

  bsd_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .stb_i       (ser_stb_i),
    .cnt_o       (byte_cnt),
    .store_en_o  (store_en),
    .last_byte_o (last_byte)
  );

  bsd_collect #(.NUM_BYTES(NUM_BYTES)) u_collect (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .store_en_i  (store_en),
    .byte_i      (ser_byte_i),
    .full_addr_o (full_addr),
    .data_o      (data_word)
  );

  assign addr_hit = bsd_pkg::addr_in_window(full_addr, BASE_ADDR, ADDR_MASK);
  assign commit   = last_byte && addr_hit;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      reg_we_o   <= 1'b0;
      reg_addr_o <= '0;
      reg_data_o <= '0;
    end else begin
      reg_we_o <= commit;
      if (commit) begin
        reg_addr_o <= full_addr[LOC_AW-1:0];
        reg_data_o <= data_word;
      end
    end
  end
endmodule

// File: tb/tb_bserial_wr_deser.sv
`timescale 1ns/1ps
module tb_bserial_wr_deser;
  localparam logic [15:0] BASE = 16'h0120;
  localparam logic [15:0] MASK = 16'h03F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] ser_byte = 8'h00;
  logic ser_stb = 1'b0;
  logic [3:0] reg_addr;
  logic [31:0] reg_data;
  logic reg_we;

  int n_tests = 0;
  int n_fail = 0;
  int pulses = 0;
  logic obs_we;
  logic [3:0] obs_addr;
  logic [31:0] obs_data;
  logic [3:0] last_addr = '0;
  logic [31:0] last_data = '0;

  always #5 clk = ~clk;

  bserial_wr_deser dut (
    .clk_i(clk), .rst_i(rst), .ser_byte_i(ser_byte), .ser_stb_i(ser_stb),
    .reg_addr_o(reg_addr), .reg_data_o(reg_data), .reg_we_o(reg_we)
  );

  function automatic bit exp_hit(input logic [15:0] a);
    for (int b = 0; b < 16; b++)
      if (MASK[b] && (a[b] != BASE[b])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // observe what the previous edge produced, then drive the next byte
  task automatic tick(input logic s, input logic [7:0] b);
    @(negedge clk);
    obs_we = reg_we; obs_addr = reg_addr; obs_data = reg_data;
    if (reg_we) pulses++;
    ser_stb = s; ser_byte = b;
  endtask

  task automatic send_body(input logic [15:0] a, input logic [31:0] d);
    tick(1'b0, a[15:8]);
    for (int k = 0; k < 4; k++) tick(1'b0, d[8*k +: 8]);
  endtask

  task automatic send_cmd(input logic [15:0] a, input logic [31:0] d);
    tick(1'b1, a[7:0]);
    send_body(a, d);
  endtask

  task automatic check_result(input logic [15:0] a, input logic [31:0] d, input string tag);
    bit h;
    h = exp_hit(a);
    if (h) begin last_addr = a[3:0]; last_data = d; end
    chk(obs_we == h, {tag, " we"}, obs_we, h);
    chk(obs_data == last_data, {tag, " data"}, obs_data, last_data);
    chk(obs_addr == last_addr, {tag, " addr"}, obs_addr, last_addr);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int p0;
    logic [15:0] a;
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) tick(1'b0, 8'h00);
    rst = 1'b0;
    tick(1'b0, 8'h00);
    // R8: reset state
    chk(obs_we == 1'b0 && obs_data == 32'h0 && obs_addr == 4'h0, "R8 reset state", {obs_we, obs_addr, obs_data}, 0);

    // R7: idle bytes without strobe do nothing
    p0 = pulses;
    repeat (10) tick(1'b0, 8'($urandom));
    tick(1'b0, 8'h00);
    chk(pulses == p0, "R7 idle bytes ignored", pulses, p0);

    // R1 R3 R4: basic accepted write
    send_cmd(16'h0125, 32'hA1B2C3D4);
    tick(1'b0, 8'h5A);
    check_result(16'h0125, 32'hA1B2C3D4, "R1 R4 basic");
    tick(1'b0, 8'h00);
    chk(obs_we == 1'b0, "R3 single cycle", obs_we, 0);

    // R5 R9: out-of-window command holds outputs
    send_cmd(16'h0135, 32'h11223344);
    tick(1'b0, 8'h00);
    check_result(16'h0135, 32'h11223344, "R5 R9 miss");

    // R2: bits outside the mask are don't-care
    send_cmd(16'hFD2A, 32'h0BADF00D);
    tick(1'b0, 8'h00);
    check_result(16'hFD2A, 32'h0BADF00D, "R2 unmasked bits");

    // R10: back-to-back commands
    send_cmd(16'h0121, 32'hCAFE0001);
    tick(1'b1, 8'h2E);
    check_result(16'h0121, 32'hCAFE0001, "R10 first");
    send_body(16'h012E, 32'hCAFE0002);
    tick(1'b0, 8'h00);
    check_result(16'h012E, 32'hCAFE0002, "R10 second");

    // R6: restart mid-command
    p0 = pulses;
    tick(1'b1, 8'h27); tick(1'b0, 8'h01); tick(1'b0, 8'h99);
    send_cmd(16'h0123, 32'h600DD00D);
    tick(1'b0, 8'h00);
    check_result(16'h0123, 32'h600DD00D, "R6 restart");
    chk(pulses == p0 + 1, "R6 single write", pulses, p0 + 1);

    // R6: strobe in the last-byte slot
    p0 = pulses;
    tick(1'b1, 8'h24); tick(1'b0, 8'h01);
    tick(1'b0, 8'h10); tick(1'b0, 8'h20); tick(1'b0, 8'h30);
    send_cmd(16'h0129, 32'h76543210);
    tick(1'b0, 8'h00);
    check_result(16'h0129, 32'h76543210, "R6 last-slot restart");
    chk(pulses == p0 + 1, "R6 last-slot single write", pulses, p0 + 1);

    // R8: reset cuts a command; leftovers never write
    p0 = pulses;
    tick(1'b1, 8'h22); tick(1'b0, 8'h01); tick(1'b0, 8'hEE);
    rst = 1'b1;
    tick(1'b0, 8'hEE);
    rst = 1'b0;
    tick(1'b0, 8'hEE); tick(1'b0, 8'hEE); tick(1'b0, 8'hEE);
    tick(1'b0, 8'h00); tick(1'b0, 8'h00);
    chk(pulses == p0, "R8 no write after cut", pulses, p0);
    chk(obs_data == 32'h0 && obs_addr == 4'h0, "R8 outputs cleared", obs_data, 0);
    last_data = '0; last_addr = '0;

    // random mix
    for (int n = 0; n < 80; n++) begin
      a = 16'($urandom);
      if ($urandom % 2) a = (BASE & MASK) | (a & ~MASK);
      d = $urandom;
      send_cmd(a, d);
      tick(1'b0, 8'($urandom));
      check_result(a, d, exp_hit(a) ? "R2 R4 random hit" : "R5 random miss");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule